// File: doc/BRIEF.md
# Converter Read Sequencer

This block runs the control port of a 12-bit sampling converter on behalf of a host. When the host asks for a sample, the sequencer drives chip select low with high-byte enable low and holds them for a set number of cycles. It then pulls the read/convert strobe low for a minimum width. The falling edge of the strobe starts a conversion. The sequencer then waits until it has seen the converter's busy line go low and come back high. Only then does it read the result.

The result is read either as one 12-bit word or, on a narrow bus, as two reads. The first read takes the low byte from data lines 7:0. The second read is made with high-byte enable raised and takes bits 11:8 from data lines 3:0. The finished sample goes out on a valid/ready port. If busy does not come back high within a limit, the sample is returned with an error flag. All minimum times are parameters counted in system clock cycles, and so is the minimum spacing between two conversion starts.

Top module: `adc_read_seq`

## Requirements
- R1: During and right after reset, `cs_n` is 1, `rc` is 1, `hbe` is 0 and `res_valid` is 0.
- R2: Before every falling edge of `rc`, `cs_n` is 0 and `hbe` is 0 with `rc` high for exactly SETUP_CYC consecutive cycles.
- R3: `rc` stays low for exactly STROBE_CYC cycles per conversion start.
- R4: The data bus is sampled only while `rc` is 1, `busy` is 1 and `cs_n` is 0, and only after `busy` has been seen low and has then returned high after the start.
- R5: With `byte_mode` 0 at request time, `res_data` equals `adc_d[11:0]`, sampled on the READ_CYC-th cycle of the single read, and `res_err` is 0.
- R6: With `byte_mode` 1, the first read (`hbe`=0) supplies `res_data[7:0]` from `adc_d[7:0]`. The second read (`hbe`=1) supplies `res_data[11:8]` from `adc_d[3:0]`. `hbe` is 1 only while `rc` is 1 and `cs_n` is 0.
- R7: If `busy` has not returned high within TIMEOUT_CYC cycles after the strobe ends, the result is presented with `res_err`=1 and `res_data`=0.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_data` and `res_err` hold unchanged.
- R9: Two falling edges of `rc` are at least GAP_CYC cycles apart. A request that is held high across the end of the interval starts its setup phase on the first cycle the interval allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request one sample (level, sampled while idle) |
| byte_mode | input | 1 | 1 = two byte reads, 0 = one word read |
| cs_n | output | 1 | Converter chip select, active low |
| rc | output | 1 | Read/convert strobe; falling edge starts a conversion |
| hbe | output | 1 | High-byte enable for the second byte read |
| busy | input | 1 | Converter busy, low while converting |
| adc_d | input | 12 | Converter data bus |
| res_valid | output | 1 | Sample available |
| res_ready | input | 1 | Host accepts sample |
| res_data | output | 12 | Sample value |
| res_err | output | 1 | Sample is a timeout error |

## Verification
The start-to-start guard and the request path act in the same cycle. This happens when the host holds `req` high straight through a handshake, so that the interval counter reaches zero at the very edge where the idle state looks at the request. The bench provokes this with back-to-back requests and a short conversion. It then measures the distance between falling strobe edges. That distance must be no less than GAP_CYC and no more than GAP_CYC plus the setup length plus two. A second overlap occurs when the converter drops busy while the strobe is still low. The bench model does this, and the captured data shows whether the sequencer read the idle-bus filler instead of the sample.

// File: rtl/adc_read_seq.sv
module adc_read_seq #(
  parameter int SETUP_CYC   = 4,
  parameter int STROBE_CYC  = 5,
  parameter int READ_CYC    = 2,
  parameter int GAP_CYC     = 375,
  parameter int TIMEOUT_CYC = 360,
  parameter int DW          = 12,
  parameter int BW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          byte_mode,
  output logic          cs_n,
  output logic          rc,
  output logic          hbe,
  input  logic          busy,
  input  logic [DW-1:0] adc_d,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          res_err
);
  localparam int HW   = DW - BW;
  localparam int MAXC = (TIMEOUT_CYC > SETUP_CYC + STROBE_CYC + READ_CYC) ?
                        TIMEOUT_CYC : SETUP_CYC + STROBE_CYC + READ_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int GW   = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_WAIT, S_RDLO, S_RDHI, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gap;
  logic          mode_q, armed;
  logic [BW-1:0] lo_q;
  logic          cap;

  assign cs_n      = !(st inside {S_SETUP, S_STROBE, S_WAIT, S_RDLO, S_RDHI});
  assign rc        = (st != S_STROBE);
  assign hbe       = (st == S_RDHI);
  assign res_valid = (st == S_DONE);
  assign cap       = (st inside {S_RDLO, S_RDHI}) && (cnt == CW'(READ_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      gap      <= '0;
      mode_q   <= 1'b0;
      armed    <= 1'b0;
      lo_q     <= '0;
      res_data <= '0;
      res_err  <= 1'b0;
    end else begin
      if (gap != '0) gap <= gap - 1'b1;
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (req && gap == '0) begin
            st     <= S_SETUP;
            mode_q <= byte_mode;
          end
        end
        S_SETUP:
          if (cnt == CW'(SETUP_CYC - 1)) begin
            st  <= S_STROBE;
            cnt <= '0;
            gap <= GW'(GAP_CYC);
          end
        S_STROBE:
          if (cnt == CW'(STROBE_CYC - 1)) begin
            st    <= S_WAIT;
            cnt   <= '0;
            armed <= 1'b0;
          end
        S_WAIT: begin
          if (!busy) armed <= 1'b1;
          if (armed && busy) begin
            st  <= S_RDLO;
            cnt <= '0;
          end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
            st       <= S_DONE;
            res_data <= '0;
            res_err  <= 1'b1;
          end
        end
        S_RDLO:
          if (cap) begin
            cnt <= '0;
            if (mode_q) begin
              lo_q <= adc_d[BW-1:0];
              st   <= S_RDHI;
            end else begin
              res_data <= adc_d;
              res_err  <= 1'b0;
              st       <= S_DONE;
            end
          end
        S_RDHI:
          if (cap) begin
            res_data <= {adc_d[HW-1:0], lo_q};
            res_err  <= 1'b0;
            st       <= S_DONE;
          end
        S_DONE:
          if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_read_seq_chk.sv
module adc_read_seq_chk #(
  parameter int GAP_CYC = 375,
  parameter int DW      = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rc,
  input logic          hbe,
  input logic          busy,
  input logic          cap,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic          res_err
);
  localparam int GW = $clog2(GAP_CYC + 2);
  logic [GW-1:0] since_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) since_fall <= GW'(GAP_CYC);
    else if (!rc && since_fall >= GW'(GAP_CYC) && $past(rc)) since_fall <= '0;
    else if (since_fall < GW'(GAP_CYC)) since_fall <= since_fall + 1'b1;
  end

  always_comb if (!rst_n) assert_reset_idle_R1: assert (cs_n && rc && !hbe && !res_valid);

  assert_setup_before_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rc) |-> !cs_n && !hbe && $past(!cs_n) && $past(!hbe));

  assert_read_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> busy && !cs_n && rc);

  assert_hbe_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hbe |-> rc && !cs_n);

  assert_err_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err |-> res_data == '0);

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_err));

  assert_start_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rc) |-> since_fall >= GW'(GAP_CYC - 1));
endmodule

bind adc_read_seq adc_read_seq_chk #(.GAP_CYC(GAP_CYC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc(rc), .hbe(hbe), .busy(busy),
  .cap(cap), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .res_err(res_err)
);

// File: tb/adc_read_seq_tb.sv
`timescale 1ns/1ps
module adc_read_seq_tb;
  localparam int SETUP = 3, STROBE = 5, RD = 2, GAP = 60, TMO = 50, CONV = 20;

  logic clk = 0, rst_n = 0, req = 0, byte_mode = 0, res_ready = 0;
  logic cs_n, rc, hbe, res_valid, res_err;
  logic busy;
  logic [11:0] adc_d, res_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  adc_read_seq #(.SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .READ_CYC(RD),
                 .GAP_CYC(GAP), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .byte_mode(byte_mode),
    .cs_n(cs_n), .rc(rc), .hbe(hbe), .busy(busy), .adc_d(adc_d),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_err(res_err));

  // converter model
  logic [11:0] next_val = 0, conv_q = 0;
  logic rc_d = 1, stuck = 0;
  int ccnt = 0;
  always @(posedge clk) begin
    rc_d <= rc;
    if (!rst_n) begin busy <= 1; ccnt <= 0; end
    else if (rc_d && !rc && !cs_n && !hbe && busy && ccnt == 0) begin
      ccnt <= 1; conv_q <= next_val;
    end else if (ccnt != 0) begin
      ccnt <= ccnt + 1;
      if (ccnt == 2) busy <= 0;
      if (ccnt >= CONV && !stuck) begin busy <= 1; ccnt <= 0; end
    end
  end
  assign adc_d = (!cs_n && rc && busy) ? (hbe ? {8'hA5, conv_q[11:8]} : conv_q) : 12'hEEE;

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp); end
  endtask

  // port monitor for R2, R3, R9
  int setup_run = 0, low_run = 0, cyc = 0, last_fall = -1, fall_gap = 0;
  logic rc_prev = 1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!rc && rc_prev) begin
        chk(setup_run == SETUP, "R2 setup cycles", setup_run, SETUP);
        if (last_fall >= 0) begin
          fall_gap = cyc - last_fall;
          chk(fall_gap >= GAP, "R9 start spacing", fall_gap, GAP);
        end
        last_fall = cyc;
      end
      if (rc && !rc_prev) chk(low_run == STROBE, "R3 strobe width", low_run, STROBE);
      if (!rc) low_run++; else low_run = 0;
      if (!cs_n && rc && !hbe) setup_run++; else setup_run = 0;
    end
    rc_prev = rc;
  end

  task automatic get_result(input string tag, output bit got);
    got = 0;
    for (int i = 0; i < 600 && !got; i++) begin
      @(negedge clk);
      if (res_valid) got = 1;
    end
    chk(got, tag, 0, 1);
  endtask

  task automatic t_reset();
    chk(cs_n && rc && !hbe && !res_valid, "R1 reset outputs", {cs_n, rc, hbe, res_valid}, 4'b1100);
  endtask

  task automatic t_sample(input bit bm, input logic [11:0] val, input string tag);
    bit got;
    logic [11:0] d0;
    @(negedge clk); next_val = val; byte_mode = bm; req = 1;
    @(negedge clk); req = 0;
    get_result(tag, got);
    chk(res_data == val && !res_err, tag, res_data, val);
    d0 = res_data;
    repeat (3) begin
      @(negedge clk);
      chk(res_valid && res_data == d0 && !res_err, "R8 hold while not ready", res_data, d0);
    end
    res_ready = 1; @(negedge clk); res_ready = 0;
    chk(!res_valid, "R8 released after ready", res_valid, 0);
  endtask

  task automatic t_timeout();
    bit got;
    repeat (GAP) @(negedge clk);
    stuck = 1; next_val = 12'h7E1; req = 1;
    @(negedge clk); req = 0;
    get_result("R7 timeout result", got);
    chk(res_err && res_data == 0, "R7 timeout error flag", {res_err, res_data}, 13'h1000);
    stuck = 0;
    res_ready = 1; @(negedge clk); res_ready = 0;
  endtask

  task automatic t_back_to_back();
    bit got;
    int f1;
    repeat (GAP) @(negedge clk);
    next_val = 12'h3C5; byte_mode = 0; res_ready = 1; req = 1;
    get_result("R9 first of pair", got);
    f1 = last_fall;
    while (last_fall == f1) @(negedge clk);
    chk(last_fall - f1 >= GAP && last_fall - f1 <= GAP + SETUP + 2,
        "R9 held request starts promptly", last_fall - f1, GAP + SETUP + 1);
    get_result("R9 second of pair", got);
    chk(res_data == 12'h3C5 && !res_err, "R5 second word", res_data, 12'h3C5);
    req = 0; @(negedge clk); res_ready = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sample(0, 12'hA5C, "R5 R4 word read");
    repeat (GAP) @(negedge clk);
    t_sample(0, 12'h000, "R5 word zero");
    repeat (GAP) @(negedge clk);
    t_sample(1, 12'h9F3, "R6 byte pair read");
    repeat (GAP) @(negedge clk);
    t_sample(1, 12'hFFF, "R6 byte all ones");
    t_timeout();
    repeat (GAP) @(negedge clk);
    t_sample(0, 12'h5A6, "R4 read after timeout recovery");
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule